// File: doc/BRIEF.md
# Capture and Up/Down Reload Timer

A 16-bit timer/counter built around a count register and a companion capture/reload register. It advances either once per machine cycle (timer mode) or once per qualified falling edge on an external count pin (counter mode). A second pin, the trigger pin, plays one of three roles depending on the mode. It can latch the running count into the companion register. It can force the count back to the reload value. Or it can pick the counting direction.

Software reaches all state through a byte-wide register port with a combinational read path. Every count, sample and trigger action is qualified by a machine-cycle enable pulse that the surrounding clock logic supplies. Two sticky flags record overflow/underflow and trigger events. Their OR forms the interrupt request.

Top module: `cap_reload_tmr`

## Requirements
- R1: After reset, every register reads 0x00 (control, both count bytes, both reload bytes), both flags are clear and irq_o is low.
- R2: The register port maps these addresses: 0 is control, 1 is count low byte, 2 is count high byte, 3 is reload low byte, 4 is reload high byte. Control bits are run=bit0, counter-select=bit1, capture-select=bit2, trigger-enable=bit3, down-enable=bit4, trigger flag=bit6 and overflow flag=bit7. Bit 5 and unmapped addresses read 0. A write takes effect at the clock edge, and the read data is combinational.
- R3: In timer mode (counter-select=0) with run=1, the count increments by one on each clock where mc_en_i is high. It holds when mc_en_i is low or run=0.
- R4: In counter mode, the count pin is sampled once per machine cycle. The count increments on the machine cycle after a sample of 1 has been followed by a sample of 0. A steady pin level does not change the count.
- R5: In capture mode (capture-select=1), a step from 0xFFFF wraps the count to 0x0000 and sets the overflow flag.
- R6: In capture mode with trigger-enable=1, a qualified falling edge on the trigger pin copies the count into the reload register and sets the trigger flag, leaving the count undisturbed. With trigger-enable=0 the edge has no effect.
- R7: In reload mode (capture-select=0) counting up, a step from 0xFFFF loads the reload value into the count and sets the overflow flag.
- R8: In reload mode with down-enable=0 and trigger-enable=1, a qualified falling trigger edge loads the reload value into the count and sets the trigger flag. This takes priority over a step in the same machine cycle.
- R9: In reload mode with down-enable=1, a sampled trigger level of 1 counts up and a level of 0 counts down. When counting down, a step with count equal to the reload value loads 0xFFFF and sets the overflow flag. Trigger edges neither reload nor set the trigger flag.
- R10: Both flags stay set until a control-register write clears them, and irq_o is high whenever either flag is set.
- R11: Trigger actions (capture, forced reload) occur on machine cycles even while run=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mc_en_i | input | 1 | Machine-cycle enable, one clock high per machine cycle |
| cnt_pin_i | input | 1 | External count pin |
| trg_pin_i | input | 1 | Trigger pin: capture, forced reload or direction |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data (combinational) |
| ovf_o | output | 1 | Overflow/underflow flag |
| exf_o | output | 1 | Trigger event flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle: that the flags stay set, that the count holds without a machine-cycle enable or with a steady count pin, the wrap to zero in capture mode, the reload on up-overflow, the load of all ones on down-underflow, and the capture copy. The bench scenarios alone show the multi-cycle behaviour. This covers the extra machine cycle of latency between a falling pin edge and its effect, the trigger acting as a direction select rather than an event in down-enabled mode, and the trigger taking priority over a step in the same cycle. It also covers trigger actions while stopped and the exact register map as seen through the byte port.

// File: rtl/cap_reload_tmr_pkg.sv
package cap_reload_tmr_pkg;
  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_LANES  = 2;
  localparam int unsigned DEF_ADDR_W = 3;

  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned CNT_BASE  = 1;
  localparam int unsigned RLD_BASE  = CNT_BASE + DEF_LANES;

  localparam int unsigned B_RUN = 0;
  localparam int unsigned B_CTR = 1;
  localparam int unsigned B_CAP = 2;
  localparam int unsigned B_EXT = 3;
  localparam int unsigned B_DN  = 4;
  localparam int unsigned B_EXF = 6;
  localparam int unsigned B_OVF = 7;

  typedef struct packed {
    logic down_en;
    logic ext_en;
    logic cap_sel;
    logic ctr_sel;
    logic run;
  } cfg_t;
endpackage

// File: rtl/crt_pin_sampler.sv
module crt_pin_sampler #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mc_en_i,
  input  logic pin_i,
  output logic level_o,
  output logic fall_o
);
  logic pin_s;
  logic samp_q, prev_q;

  if (SYNC_STAGES > 0) begin : g_sync
    logic [SYNC_STAGES-1:0] sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sync_q <= '0;
      end else begin
        sync_q[0] <= pin_i;
        for (int k = 1; k < SYNC_STAGES; k++) sync_q[k] <= sync_q[k-1];
      end
    end
    assign pin_s = sync_q[SYNC_STAGES-1];
  end else begin : g_nosync
    assign pin_s = pin_i;
  end

  // one sample per machine cycle; edge is qualified against the previous sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= 1'b0;
      prev_q <= 1'b0;
    end else if (mc_en_i) begin
      samp_q <= pin_s;
      prev_q <= samp_q;
    end
  end

  assign level_o = samp_q;
  assign fall_o  = prev_q & ~samp_q;
endmodule

// File: rtl/crt_regs.sv
module crt_regs
  import cap_reload_tmr_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  localparam int unsigned CNT_W = DATA_W * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              ovf_set_i,
  input  logic              exf_set_i,
  input  logic              cap_load_i,
  output cfg_t              cfg_o,
  output logic [CNT_W-1:0]  rld_o,
  output logic              ovf_o,
  output logic              exf_o,
  output logic [LANES-1:0]  cnt_we_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [LANES-1:0] rld_we;
  logic             ctrl_we;

  assign ctrl_we = wr_i && (addr_i == ADDR_W'(ADDR_CTRL));

  for (genvar l = 0; l < LANES; l++) begin : g_dec
    assign cnt_we_o[l] = wr_i && (addr_i == ADDR_W'(CNT_BASE + l));
    assign rld_we[l]   = wr_i && (addr_i == ADDR_W'(RLD_BASE + l));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= '0;
      ovf_o <= 1'b0;
      exf_o <= 1'b0;
    end else begin
      if (ctrl_we) begin
        cfg_o.run     <= wdata_i[B_RUN];
        cfg_o.ctr_sel <= wdata_i[B_CTR];
        cfg_o.cap_sel <= wdata_i[B_CAP];
        cfg_o.ext_en  <= wdata_i[B_EXT];
        cfg_o.down_en <= wdata_i[B_DN];
        ovf_o         <= wdata_i[B_OVF] | ovf_set_i;
        exf_o         <= wdata_i[B_EXF] | exf_set_i;
      end else begin
        ovf_o <= ovf_o | ovf_set_i;
        exf_o <= exf_o | exf_set_i;
      end
    end
  end

  // software byte write wins over a capture in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rld_o <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (rld_we[l])       rld_o[l*DATA_W +: DATA_W] <= wdata_i;
        else if (cap_load_i) rld_o[l*DATA_W +: DATA_W] <= cnt_i[l*DATA_W +: DATA_W];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADDR_CTRL)) begin
      rdata_o[B_RUN] = cfg_o.run;
      rdata_o[B_CTR] = cfg_o.ctr_sel;
      rdata_o[B_CAP] = cfg_o.cap_sel;
      rdata_o[B_EXT] = cfg_o.ext_en;
      rdata_o[B_DN]  = cfg_o.down_en;
      rdata_o[B_EXF] = exf_o;
      rdata_o[B_OVF] = ovf_o;
    end
    for (int l = 0; l < LANES; l++) begin
      if (addr_i == ADDR_W'(CNT_BASE + l)) rdata_o = cnt_i[l*DATA_W +: DATA_W];
      if (addr_i == ADDR_W'(RLD_BASE + l)) rdata_o = rld_o[l*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/crt_count_core.sv
module crt_count_core
  import cap_reload_tmr_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned LANES  = DEF_LANES,
  localparam int unsigned CNT_W = DATA_W * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mc_en_i,
  input  cfg_t              cfg_i,
  input  logic              cnt_fall_i,
  input  logic              trg_lvl_i,
  input  logic              trg_fall_i,
  input  logic [CNT_W-1:0]  rld_i,
  input  logic [LANES-1:0]  cnt_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              ovf_set_o,
  output logic              exf_set_o,
  output logic              cap_load_o
);
  logic [CNT_W-1:0] cnt_d;
  logic step, trg_act, count_up;

  assign step     = mc_en_i && cfg_i.run && (cfg_i.ctr_sel ? cnt_fall_i : 1'b1);
  assign trg_act  = mc_en_i && cfg_i.ext_en && trg_fall_i;
  // direction only selectable in reload mode with down counting enabled
  assign count_up = !(!cfg_i.cap_sel && cfg_i.down_en) || trg_lvl_i;

  always_comb begin
    cnt_d      = cnt_o;
    ovf_set_o  = 1'b0;
    exf_set_o  = 1'b0;
    cap_load_o = 1'b0;

    if (step) begin
      if (count_up) begin
        if (cnt_o == '1) begin
          ovf_set_o = 1'b1;
          cnt_d     = cfg_i.cap_sel ? '0 : rld_i;
        end else begin
          cnt_d = cnt_o + 1'b1;
        end
      end else begin
        if (cnt_o == rld_i) begin
          ovf_set_o = 1'b1;
          cnt_d     = '1;
        end else begin
          cnt_d = cnt_o - 1'b1;
        end
      end
    end

    if (cfg_i.cap_sel) begin
      if (trg_act) begin
        cap_load_o = 1'b1;
        exf_set_o  = 1'b1;
      end
    end else if (!cfg_i.down_en && trg_act) begin
      cnt_d     = rld_i;
      exf_set_o = 1'b1;
    end

    for (int l = 0; l < LANES; l++) begin
      if (cnt_we_i[l]) cnt_d[l*DATA_W +: DATA_W] = wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_d;
  end
endmodule

// File: rtl/cap_reload_tmr.sv
module cap_reload_tmr
  import cap_reload_tmr_pkg::*;
#(
  parameter int unsigned DATA_W      = DEF_DATA_W,
  parameter int unsigned LANES       = DEF_LANES,
  parameter int unsigned ADDR_W      = DEF_ADDR_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mc_en_i,
  input  logic              cnt_pin_i,
  input  logic              trg_pin_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ovf_o,
  output logic              exf_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W  = DATA_W * LANES;
  localparam int unsigned N_PINS = 2;

  logic [N_PINS-1:0] pin_vec, pin_lvl, pin_fall;
  logic              cnt_lvl, cnt_fall, trg_lvl, trg_fall;
  cfg_t              cfg;
  logic [CNT_W-1:0]  cnt_q, rld_q;
  logic [LANES-1:0]  cnt_we;
  logic              ovf_set, exf_set, cap_load;

  assign pin_vec = {trg_pin_i, cnt_pin_i};

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    crt_pin_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .mc_en_i (mc_en_i),
      .pin_i   (pin_vec[p]),
      .level_o (pin_lvl[p]),
      .fall_o  (pin_fall[p])
    );
  end

  assign cnt_lvl  = pin_lvl[0];
  assign cnt_fall = pin_fall[0];
  assign trg_lvl  = pin_lvl[1];
  assign trg_fall = pin_fall[1];

  crt_regs #(.DATA_W(DATA_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .cnt_i      (cnt_q),
    .ovf_set_i  (ovf_set),
    .exf_set_i  (exf_set),
    .cap_load_i (cap_load),
    .cfg_o      (cfg),
    .rld_o      (rld_q),
    .ovf_o      (ovf_o),
    .exf_o      (exf_o),
    .cnt_we_o   (cnt_we),
    .rdata_o    (rdata_o)
  );

  crt_count_core #(.DATA_W(DATA_W), .LANES(LANES)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mc_en_i    (mc_en_i),
    .cfg_i      (cfg),
    .cnt_fall_i (cnt_fall),
    .trg_lvl_i  (trg_lvl),
    .trg_fall_i (trg_fall),
    .rld_i      (rld_q),
    .cnt_we_i   (cnt_we),
    .wdata_i    (wdata_i),
    .cnt_o      (cnt_q),
    .ovf_set_o  (ovf_set),
    .exf_set_o  (exf_set),
    .cap_load_o (cap_load)
  );

  assign irq_o = ovf_o | exf_o;
endmodule

// File: rtl/cap_reload_tmr_chk.sv
module cap_reload_tmr_chk
  import cap_reload_tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mc_en_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input cfg_t              cfg,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  rld,
  input logic              cnt_lvl,
  input logic              trg_lvl,
  input logic              trg_fall,
  input logic              ovf,
  input logic              exf
);
  logic ctrl_wr;
  assign ctrl_wr = wr_i && (addr_i == ADDR_W'(ADDR_CTRL));

  // R10
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf && !ctrl_wr |=> ovf);

  // R10
  exf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exf && !ctrl_wr |=> exf);

  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mc_en_i && !wr_i |=> $stable(cnt));

  // R4
  steady_pin_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.ctr_sel && cfg.cap_sel && cnt_lvl && !wr_i |=> $stable(cnt));

  // R5
  cap_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mc_en_i && cfg.run && !cfg.ctr_sel && cfg.cap_sel && (cnt == '1) && !wr_i
    |=> (cnt == '0) && ovf);

  // R6
  capture_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mc_en_i && cfg.cap_sel && cfg.ext_en && trg_fall && !wr_i
    |=> (rld == $past(cnt)) && exf);

  // R7
  up_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mc_en_i && cfg.run && !cfg.ctr_sel && !cfg.cap_sel && !cfg.down_en && (cnt == '1) && !wr_i
    |=> (cnt == $past(rld)) && ovf);

  // R9
  down_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mc_en_i && cfg.run && !cfg.ctr_sel && !cfg.cap_sel && cfg.down_en && !trg_lvl
    && (cnt == rld) && !wr_i
    |=> (cnt == '1) && ovf);
endmodule

bind cap_reload_tmr cap_reload_tmr_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mc_en_i  (mc_en_i),
  .wr_i     (wr_i),
  .addr_i   (addr_i),
  .cfg      (cfg),
  .cnt      (cnt_q),
  .rld      (rld_q),
  .cnt_lvl  (cnt_lvl),
  .trg_lvl  (trg_lvl),
  .trg_fall (trg_fall),
  .ovf      (ovf_o),
  .exf      (exf_o)
);

// File: tb/cap_reload_tmr_test.sv
`timescale 1ns/1ps
module cap_reload_tmr_test;
  localparam logic [7:0] C_RUN = 8'h01, C_CTR = 8'h02, C_CAP = 8'h04,
                         C_EXT = 8'h08, C_DN = 8'h10, F_EXF = 8'h40, F_OVF = 8'h80;
  localparam logic [2:0] A_CTRL = 3'd0, A_CLO = 3'd1, A_CHI = 3'd2, A_RLO = 3'd3, A_RHI = 3'd4;

  logic clk = 1'b0, rst_n = 1'b0, mc_en = 1'b0, cnt_pin = 1'b1, trg_pin = 1'b1;
  logic wr = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic ovf, exf, irq;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  cap_reload_tmr uut (
    .clk_i(clk), .rst_ni(rst_n), .mc_en_i(mc_en), .cnt_pin_i(cnt_pin), .trg_pin_i(trg_pin),
    .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .ovf_o(ovf), .exf_o(exf), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic rd_cnt(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd_reg(A_CLO, lo); rd_reg(A_CHI, hi); v = {hi, lo};
  endtask

  task automatic rd_rld(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd_reg(A_RLO, lo); rd_reg(A_RHI, hi); v = {hi, lo};
  endtask

  task automatic set_cnt(input logic [15:0] v);
    wr_reg(A_CLO, v[7:0]); wr_reg(A_CHI, v[15:8]);
  endtask

  task automatic set_rld(input logic [15:0] v);
    wr_reg(A_RLO, v[7:0]); wr_reg(A_RHI, v[15:8]);
  endtask

  task automatic mcyc(input int n);
    for (int i = 0; i < n; i++) begin
      repeat (3) @(negedge clk);
      mc_en = 1'b1;
      @(negedge clk);
      mc_en = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 5; a++) begin
      rd_reg(3'(a), d);
      chk("R1 reset reg", {8'h0, d}, 16'h0);
    end
    chk("R1 reset irq", {15'h0, irq}, 16'h0);
  endtask

  task automatic t_regs();
    logic [15:0] v;
    logic [7:0] d;
    set_cnt(16'hA55A); rd_cnt(v); chk("R2 count bytes", v, 16'hA55A);
    set_rld(16'h3CC3); rd_rld(v); chk("R2 reload bytes", v, 16'h3CC3);
    wr_reg(A_CTRL, 8'h3F); rd_reg(A_CTRL, d); chk("R2 ctrl bit5 reads 0", {8'h0, d}, 16'h001F);
    wr_reg(A_CTRL, 8'h00);
    rd_reg(3'd5, d); chk("R2 unmapped addr", {8'h0, d}, 16'h0);
  endtask

  task automatic t_timer();
    logic [15:0] v;
    set_cnt(16'h0010);
    wr_reg(A_CTRL, C_RUN | C_CAP);
    mcyc(5); rd_cnt(v); chk("R3 timer counts", v, 16'h0015);
    repeat (10) @(negedge clk);
    rd_cnt(v); chk("R3 hold without mc_en", v, 16'h0015);
    wr_reg(A_CTRL, C_CAP);
    mcyc(3); rd_cnt(v); chk("R3 hold when stopped", v, 16'h0015);
  endtask

  task automatic t_counter();
    logic [15:0] v;
    set_cnt(16'h0000);
    wr_reg(A_CTRL, C_RUN | C_CTR | C_CAP);
    cnt_pin = 1'b1; mcyc(2);
    rd_cnt(v); chk("R4 steady high", v, 16'h0000);
    cnt_pin = 1'b0; mcyc(1);
    rd_cnt(v); chk("R4 no count on detect cycle", v, 16'h0000);
    mcyc(1); rd_cnt(v); chk("R4 count after fall", v, 16'h0001);
    mcyc(3); rd_cnt(v); chk("R4 steady low", v, 16'h0001);
    cnt_pin = 1'b1; mcyc(2); rd_cnt(v); chk("R4 rising no count", v, 16'h0001);
    cnt_pin = 1'b0; mcyc(2); rd_cnt(v); chk("R4 second fall", v, 16'h0002);
    cnt_pin = 1'b1; mcyc(1);
    wr_reg(A_CTRL, 8'h00);
  endtask

  task automatic t_cap_ovf();
    logic [15:0] v;
    logic [7:0] d;
    set_cnt(16'hFFFE);
    wr_reg(A_CTRL, C_RUN | C_CAP);
    mcyc(1); rd_reg(A_CTRL, d); chk("R5 no flag before wrap", {15'h0, d[7]}, 16'h0);
    mcyc(1); rd_cnt(v); chk("R5 wrap to zero", v, 16'h0000);
    rd_reg(A_CTRL, d); chk("R5 overflow flag", {15'h0, d[7]}, 16'h1);
    chk("R10 irq from overflow", {15'h0, irq}, 16'h1);
    mcyc(2); rd_reg(A_CTRL, d); chk("R10 flag sticky", {15'h0, d[7]}, 16'h1);
    wr_reg(A_CTRL, C_CAP);
    rd_reg(A_CTRL, d); chk("R10 flag cleared by write", {15'h0, d[7]}, 16'h0);
    chk("R10 irq low after clear", {15'h0, irq}, 16'h0);
  endtask

  task automatic t_capture();
    logic [15:0] v;
    logic [7:0] d;
    set_cnt(16'h1234); set_rld(16'h0000);
    wr_reg(A_CTRL, C_CAP | C_EXT);
    trg_pin = 1'b0; mcyc(2);
    rd_rld(v); chk("R6 R11 capture while stopped", v, 16'h1234);
    rd_cnt(v); chk("R6 count undisturbed", v, 16'h1234);
    rd_reg(A_CTRL, d); chk("R6 trigger flag", {15'h0, d[6]}, 16'h1);
    chk("R10 irq from trigger flag", {15'h0, irq}, 16'h1);
    trg_pin = 1'b1; mcyc(2);
    set_rld(16'h0000); set_cnt(16'h4321);
    wr_reg(A_CTRL, C_CAP);
    trg_pin = 1'b0; mcyc(2);
    rd_rld(v); chk("R6 disabled trigger no capture", v, 16'h0000);
    rd_reg(A_CTRL, d); chk("R6 disabled trigger no flag", {15'h0, d[6]}, 16'h0);
    trg_pin = 1'b1; mcyc(2);
  endtask

  task automatic t_reload_up();
    logic [15:0] v;
    logic [7:0] d;
    set_rld(16'hFF00); set_cnt(16'hFFFE);
    wr_reg(A_CTRL, C_RUN);
    mcyc(2); rd_cnt(v); chk("R7 reload on overflow", v, 16'hFF00);
    rd_reg(A_CTRL, d); chk("R7 overflow flag", {15'h0, d[7]}, 16'h1);
    mcyc(1); rd_cnt(v); chk("R7 counts on from reload", v, 16'hFF01);
    wr_reg(A_CTRL, 8'h00);
  endtask

  task automatic t_reload_ext();
    logic [15:0] v;
    logic [7:0] d;
    set_rld(16'h8000); set_cnt(16'h0100);
    wr_reg(A_CTRL, C_RUN | C_EXT);
    trg_pin = 1'b0; mcyc(2);
    rd_cnt(v); chk("R8 forced reload wins over step", v, 16'h8000);
    rd_reg(A_CTRL, d); chk("R8 trigger flag", {15'h0, d[6]}, 16'h1);
    chk("R8 no overflow flag", {15'h0, d[7]}, 16'h0);
    trg_pin = 1'b1; mcyc(2);
    rd_cnt(v); chk("R8 counting resumes", v, 16'h8002);
    wr_reg(A_CTRL, 8'h00);
  endtask

  task automatic t_updown();
    logic [15:0] v;
    logic [7:0] d;
    set_rld(16'h0005);
    wr_reg(A_CTRL, C_DN | C_EXT);
    trg_pin = 1'b0; mcyc(2);
    set_cnt(16'h0007);
    wr_reg(A_CTRL, C_RUN | C_DN | C_EXT);
    mcyc(2); rd_cnt(v); chk("R9 counts down on low trigger", v, 16'h0005);
    mcyc(1); rd_cnt(v); chk("R9 underflow loads all ones", v, 16'hFFFF);
    rd_reg(A_CTRL, d); chk("R9 underflow flag", {15'h0, d[7]}, 16'h1);
    chk("R9 trigger edge sets no flag", {15'h0, d[6]}, 16'h0);
    wr_reg(A_CTRL, C_DN | C_EXT);
    trg_pin = 1'b1; mcyc(2);
    set_cnt(16'hFFFE);
    wr_reg(A_CTRL, C_RUN | C_DN | C_EXT);
    mcyc(1); rd_cnt(v); chk("R9 counts up on high trigger", v, 16'hFFFF);
    mcyc(1); rd_cnt(v); chk("R9 up overflow reloads", v, 16'h0005);
    rd_reg(A_CTRL, d); chk("R9 up overflow flag", {15'h0, d[7]}, 16'h1);
    wr_reg(A_CTRL, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_regs();
    t_timer();
    t_counter();
    t_cap_ovf();
    t_capture();
    t_reload_up();
    t_reload_ext();
    t_updown();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule